// File: doc/BRIEF.md
# Debug Control and Status Register with Imprecise-Error Deferral

This block holds the 32-bit control and status word that a processor core keeps for its debug mode, together with the update logic around it. Hardware events change its status fields. These events are a debug-exception entry with a type code, an exception taken while already in debug mode with a cause code, and a return from debug mode. Software reaches the few writable fields through a plain write port. The block also drives a single-step enable and a debug-mode flag.

The block also guards the core against imprecise errors that arrive while debug code runs. There are four sources: a bus error on an instruction fetch, a bus error on a data access, a cache error and a machine check. Each source latches into its own sticky pending bit. A deferral flag is set by hardware whenever debug code starts handling an event. While that flag is set, the exception request stays low. Once it clears, the highest-priority pending source is reported, and an acknowledge retires that one source.

Top module: `dbgctl_top`

## Requirements
- R1: After reset the read value is 0x0000_8000 and singleStepEn, inDebug and errReq are 0.
- R2: Bits 19:18, 9 and 7:6 always read 0. Bits 17:15 always read the constant 1. Writes to these bits have no effect.
- R3: On dbgEntry, the flag at bit index dbgType is set and the other five flags (bits 5:0) are cleared. The type codes are 0 single step, 1 software breakpoint, 2 load data break, 3 store data break, 4 instruction break and 5 debug interrupt; codes 6 and 7 clear all six flags. dbgEntry also sets inDebug and the deferral flag (bit 20). The cause field is left unchanged.
- R4: On excInDbg, excCode is loaded into bits 14:10, flags 5:0 are cleared and bit 20 is set.
- R5: dbgReturn clears bit 20 and inDebug. If dbgEntry or excInDbg arrives in the same cycle, the set takes precedence.
- R6: A write updates bit 8, which drives singleStepEn, and bit 5. Written values for bits 4:0 and 14:10 are ignored.
- R7: A write changes bit 20 only while inDebug is 1. Outside debug mode the written value of bit 20 is ignored.
- R8: When a hardware event and a software write target the same field in the same cycle, the hardware result is kept.
- R9: errIn bit 0 is a fetch bus error, bit 1 a data bus error, bit 2 a cache error and bit 3 a machine check. Each error sets its own sticky pending bit. errReq is 1 exactly when some pending bit is set and bit 20 is 0.
- R10: errSrc names the highest pending source, with priority 3 over 2 over 1 over 0. errAck clears only that source's pending bit, and only while errReq is 1. An errAck while errReq is 0 changes nothing.
- R11: If a source raises a new error in the cycle its pending bit is acknowledged, the pending bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Software write strobe |
| wrData | input | 32 | Software write data |
| dbgEntry | input | 1 | Debug exception taken |
| dbgType | input | 3 | Type code of the debug exception |
| excInDbg | input | 1 | Exception taken while in debug mode |
| excCode | input | 5 | Cause code of that exception |
| dbgReturn | input | 1 | Return from debug mode |
| errIn | input | 4 | Imprecise error indications |
| errAck | input | 1 | Acknowledge of the reported error |
| rdData | output | 32 | Register read value |
| singleStepEn | output | 1 | Single-step enable |
| inDebug | output | 1 | Debug-mode flag |
| errReq | output | 1 | Deferred imprecise-error exception request |
| errSrc | output | 2 | Index of the reported error source |

## Verification
Two pairs of functions can fall in the same cycle. The first is a software write and a hardware event aimed at the same field. The bench provokes this by writing bit 5 and bit 20 in the cycle that an exception in debug mode arrives, and it expects the hardware values to be kept. The second is an acknowledge that coincides with a fresh error on the acknowledged source; the pending bit must survive that cycle. A debug return coinciding with a debug entry is also driven, and the expected result is that the mode stays set. Every cycle's read value and outputs are compared with a bench model written from the requirements.

// File: rtl/dbgctl_pkg.sv
package dbgctl_pkg;
  localparam int REG_W    = 32;
  localparam int INH_BIT  = 20;
  localparam int VER_LO   = 15;
  localparam int VER_W    = 3;
  localparam int CAUSE_LO = 10;
  localparam int CAUSE_W  = 5;
  localparam int SST_BIT  = 8;
  localparam int FLAG_W   = 6;
  localparam int DINT_BIT = 5;
  localparam int TYPE_W   = 3;

  typedef struct packed {
    logic              setInh;
    logic              clrInh;
    logic              swInhWe;
    logic              loadCause;
    logic              clrFlags;
    logic              loadFlags;
    logic [FLAG_W-1:0] flagVal;
    logic              swSstWe;
    logic              swDintWe;
    logic              setDbg;
    logic              clrDbg;
  } ctlStrb_t;
endpackage

// File: rtl/dbgctl_control.sv
module dbgctl_control
  import dbgctl_pkg::*;
(
  input  logic              wrEn,
  input  logic              dbgEntry,
  input  logic [TYPE_W-1:0] dbgType,
  input  logic              excInDbg,
  input  logic              dbgReturn,
  input  logic              inDebug,
  output ctlStrb_t          strb
);
  logic [FLAG_W-1:0] oneHot;

  // one-hot decode of the debug exception type; out-of-range codes give zero
  for (genvar i = 0; i < FLAG_W; i++) begin : g_dec
    assign oneHot[i] = (dbgType == TYPE_W'(i));
  end

  always_comb begin
    strb           = '0;
    // hardware set beats return, return beats software
    strb.setInh    = dbgEntry | excInDbg;
    strb.clrInh    = dbgReturn & ~strb.setInh;
    strb.swInhWe   = wrEn & inDebug & ~strb.setInh & ~dbgReturn;
    strb.loadCause = excInDbg;
    strb.clrFlags  = excInDbg;
    strb.loadFlags = dbgEntry & ~excInDbg;
    strb.flagVal   = oneHot;
    strb.swSstWe   = wrEn;
    strb.swDintWe  = wrEn & ~dbgEntry & ~excInDbg;
    strb.setDbg    = dbgEntry;
    strb.clrDbg    = dbgReturn & ~dbgEntry;
  end
endmodule

// File: rtl/dbgctl_datapath.sv
module dbgctl_datapath
  import dbgctl_pkg::*;
#(
  parameter int VERSION = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrb_t           strb,
  input  logic [REG_W-1:0]   wrData,
  input  logic [CAUSE_W-1:0] excCode,
  output logic [REG_W-1:0]   rdData,
  output logic               inhibit,
  output logic               inDebug,
  output logic               singleStepEn
);
  logic               inhReg;
  logic [CAUSE_W-1:0] causeReg;
  logic               sstReg;
  logic [FLAG_W-1:0]  flagReg;
  logic               dbgReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inhReg   <= 1'b0;
      causeReg <= '0;
      sstReg   <= 1'b0;
      flagReg  <= '0;
      dbgReg   <= 1'b0;
    end else begin
      if (strb.setInh)       inhReg <= 1'b1;
      else if (strb.clrInh)  inhReg <= 1'b0;
      else if (strb.swInhWe) inhReg <= wrData[INH_BIT];

      if (strb.loadCause) causeReg <= excCode;

      if (strb.swSstWe) sstReg <= wrData[SST_BIT];

      if (strb.clrFlags)       flagReg <= '0;
      else if (strb.loadFlags) flagReg <= strb.flagVal;
      else if (strb.swDintWe)  flagReg[DINT_BIT] <= wrData[DINT_BIT];

      if (strb.setDbg)      dbgReg <= 1'b1;
      else if (strb.clrDbg) dbgReg <= 1'b0;
    end
  end

  always_comb begin
    rdData                              = '0;
    rdData[INH_BIT]                     = inhReg;
    rdData[VER_LO +: VER_W]             = VER_W'(VERSION);
    rdData[CAUSE_LO +: CAUSE_W]         = causeReg;
    rdData[SST_BIT]                     = sstReg;
    rdData[FLAG_W-1:0]                  = flagReg;
  end

  assign inhibit      = inhReg;
  assign inDebug      = dbgReg;
  assign singleStepEn = sstReg;

  // R8
  hw_flags_win_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrFlags |=> flagReg == '0);
  // R7
  inh_outside_dbg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dbgReg && !strb.setInh) |=> !inhReg || $past(inhReg));
endmodule

// File: rtl/dbgctl_errq.sv
module dbgctl_errq #(
  parameter int NUM_SRC = 4,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] errIn,
  input  logic               errAck,
  input  logic               inhibit,
  output logic               errReq,
  output logic [SRC_W-1:0]   errSrc
);
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] clrVec;

  // highest index has priority
  always_comb begin
    errSrc = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend[i]) errSrc = SRC_W'(i);
    end
  end

  assign errReq = (|pend) & ~inhibit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pend
    assign clrVec[i] = errAck & errReq & (errSrc == SRC_W'(i));
    always_ff @(posedge clk) begin
      if (!rstN) pend[i] <= 1'b0;
      else       pend[i] <= (pend[i] & ~clrVec[i]) | errIn[i];
    end
  end

  // R9
  req_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    inhibit |-> !errReq);
  // R10
  src_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    errReq |-> pend[errSrc]);
  // R11
  ack_retires_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errReq && errAck && !errIn[errSrc]) |=> !pend[$past(errSrc)]);
endmodule

// File: rtl/dbgctl_top.sv
module dbgctl_top
  import dbgctl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  input  logic        dbgEntry,
  input  logic [2:0]  dbgType,
  input  logic        excInDbg,
  input  logic [4:0]  excCode,
  input  logic        dbgReturn,
  input  logic [3:0]  errIn,
  input  logic        errAck,
  output logic [31:0] rdData,
  output logic        singleStepEn,
  output logic        inDebug,
  output logic        errReq,
  output logic [1:0]  errSrc
);
  ctlStrb_t strb;
  logic     inhibit;

  dbgctl_control u_ctl (
    .wrEn      (wrEn),
    .dbgEntry  (dbgEntry),
    .dbgType   (dbgType),
    .excInDbg  (excInDbg),
    .dbgReturn (dbgReturn),
    .inDebug   (inDebug),
    .strb      (strb)
  );

  dbgctl_datapath #(.VERSION(1)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .wrData       (wrData),
    .excCode      (excCode),
    .rdData       (rdData),
    .inhibit      (inhibit),
    .inDebug      (inDebug),
    .singleStepEn (singleStepEn)
  );

  dbgctl_errq #(.NUM_SRC(4)) u_err (
    .clk     (clk),
    .rstN    (rstN),
    .errIn   (errIn),
    .errAck  (errAck),
    .inhibit (inhibit),
    .errReq  (errReq),
    .errSrc  (errSrc)
  );

  // R3
  entry_sets_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    dbgEntry |=> inDebug && rdData[INH_BIT]);
  // R4
  exc_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    excInDbg |=> rdData[FLAG_W-1:0] == '0 && rdData[CAUSE_LO +: CAUSE_W] == $past(excCode));
  // R5
  return_leaves_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dbgReturn && !dbgEntry && !excInDbg) |=> !inDebug && !rdData[INH_BIT]);
  // R6
  sst_follows_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> singleStepEn == $past(wrData[SST_BIT]));
endmodule

// File: tb/sim_dbgctl_top.sv
module sim_dbgctl_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        dbgEntry = 1'b0;
  logic [2:0]  dbgType = '0;
  logic        excInDbg = 1'b0;
  logic [4:0]  excCode = '0;
  logic        dbgReturn = 1'b0;
  logic [3:0]  errIn = '0;
  logic        errAck = 1'b0;
  logic [31:0] rdData;
  logic        singleStepEn, inDebug, errReq;
  logic [1:0]  errSrc;

  always #5 clk = ~clk;

  dbgctl_top u0 (.*);

  typedef struct {
    logic [31:0] rd;
    logic        sst;
    logic        dbg;
    logic        req;
    logic [1:0]  src;
    string       tag;
  } exp_t;

  exp_t q[$];
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // bench model state
  logic       mInh = 0, mSst = 0, mDbg = 0;
  logic [4:0] mCause = 0;
  logic [5:0] mFlags = 0;
  logic [3:0] mPend = 0;

  function automatic logic [1:0] topSrc(logic [3:0] p);
    if (p[3]) return 2'd3;
    if (p[2]) return 2'd2;
    if (p[1]) return 2'd1;
    return 2'd0;
  endfunction

  task automatic step(input logic we, input logic [31:0] wd, input logic en,
                      input logic [2:0] ty, input logic ex, input logic [4:0] cd,
                      input logic rt, input logic [3:0] er, input logic ak,
                      input string tag);
    exp_t e;
    logic prevReq;
    logic [1:0] prevSrc;
    logic [3:0] clr;
    @(negedge clk);
    wrEn = we; wrData = wd; dbgEntry = en; dbgType = ty; excInDbg = ex;
    excCode = cd; dbgReturn = rt; errIn = er; errAck = ak;
    prevReq = (|mPend) && !mInh;
    prevSrc = topSrc(mPend);
    if (en || ex) mInh = 1;
    else if (rt) mInh = 0;
    else if (we && mDbg) mInh = wd[20];
    if (en) mDbg = 1; else if (rt) mDbg = 0;
    if (ex) mCause = cd;
    if (ex) mFlags = 0;
    else if (en) mFlags = (ty < 6) ? (6'd1 << ty) : 6'd0;
    else if (we) mFlags[5] = wd[5];
    if (we) mSst = wd[8];
    clr = (ak && prevReq) ? (4'd1 << prevSrc) : 4'd0;
    mPend = (mPend & ~clr) | er;
    e.rd  = {11'b0, mInh, 2'b0, 3'd1, mCause, 1'b0, mSst, 2'b0, mFlags};
    e.sst = mSst;
    e.dbg = mDbg;
    e.req = (|mPend) && !mInh;
    e.src = topSrc(mPend);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 4'd0, 0, tag);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      compared++;
      if (rdData !== e.rd || singleStepEn !== e.sst || inDebug !== e.dbg ||
          errReq !== e.req || (e.req && errSrc !== e.src)) begin
        mismatched++;
        $display("FAIL %s: actual rd=%h sst=%b dbg=%b req=%b src=%0d expected rd=%h sst=%b dbg=%b req=%b src=%0d",
                 e.tag, rdData, singleStepEn, inDebug, errReq, errSrc,
                 e.rd, e.sst, e.dbg, e.req, e.src);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    idle("R1 reset state");
    step(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0, "R2 R6 R7 write all ones outside debug");
    step(1, 32'h0000_0000, 0, 0, 0, 0, 0, 0, 0, "R6 write zero");
    step(0, 0, 1, 3'd2, 0, 0, 0, 0, 0, "R3 entry load break");
    step(0, 0, 1, 3'd5, 0, 0, 0, 0, 0, "R3 entry interrupt");
    step(0, 0, 1, 3'd4, 0, 0, 0, 0, 0, "R3 entry instr break");
    step(0, 0, 1, 3'd7, 0, 0, 0, 0, 0, "R3 entry bad type");
    step(1, 32'h0000_0100, 0, 0, 0, 0, 0, 0, 0, "R7 clear inhibit in debug");
    step(1, 32'h0010_0000, 0, 0, 0, 0, 0, 0, 0, "R7 set inhibit in debug");
    step(0, 0, 1, 3'd0, 0, 0, 0, 0, 0, "R3 entry single step");
    step(0, 0, 0, 0, 1, 5'h1C, 0, 0, 0, "R4 exception in debug");
    step(1, 32'h000F_FD3F, 0, 0, 0, 0, 0, 0, 0, "R2 R6 ignored fields");
    step(1, 32'h0000_0020, 0, 0, 1, 5'h07, 0, 0, 0, "R8 hw beats sw");
    step(0, 0, 0, 0, 0, 0, 0, 4'b0101, 0, "R9 errors held while inhibited");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R9 ack while inhibited ignored");
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, "R5 R9 return releases");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R10 ack cache error");
    step(0, 0, 0, 0, 0, 0, 0, 4'b0001, 1, "R11 ack with new error");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R10 ack fetch error");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R10 ack while idle");
    step(0, 0, 0, 0, 0, 0, 0, 4'b1111, 0, "R10 all sources");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R10 ack mcheck");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R10 ack cache");
    step(0, 0, 0, 0, 0, 0, 0, 4'b0010, 1, "R11 ack data with new data error");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R10 ack data");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R10 ack fetch");
    step(1, 32'h0010_0000, 0, 0, 0, 0, 0, 0, 0, "R7 inhibit write outside debug");
    step(0, 0, 1, 3'd3, 0, 0, 1, 0, 0, "R5 entry with return");
    step(0, 0, 0, 0, 1, 5'h04, 1, 4'b1000, 0, "R5 exception with return");
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, "R5 plain return");
    step(0, 0, 1, 3'd1, 0, 0, 0, 0, 0, "R3 entry sw breakpoint");
    step(0, 0, 0, 0, 0, 0, 1, 0, 1, "R10 return then report");
    idle("R8 final state");
    idle("R1 hold");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule